// File: doc/BRIEF.md
# Framed Serial Command and Result Port

This block is the digital serial front end of a two-channel sampling converter with a 12-bit magnitude and a sign bit. A host opens a frame by pulling the active-low select low, then gives 16 serial clocks. During the frame the block does three things. It shifts a command word in from the data input. It decodes a three-bit header from that word and may write the control register or the range register. At the same time it shifts the previous conversion result out on a data output that can be switched to high impedance.

The analog sampling path is not part of this block. That path receives two single-cycle strobes: one marks the hold instant and one marks the return to tracking. The conversion result reaches the block as parallel inputs, and the block captures it at the start of each frame.

All serial pins are sampled by a fast system clock. An optional synchronizer sits in front of the edge detection, so every serial event reaches the outputs a fixed few system cycles after the pin changes.

Top module: `sfe_serial_port`

## Requirements
- R1: After reset the control register reads 0, the range register reads 0 (the ±10 V code on both channels), and the output enable is low.
- R2: The output enable rises after a select fall and drops after the 16th serial clock falling edge of the frame.
- R3: The serial output presents a 16-bit word MSB first: bits 15 and 14 are zero, bit 13 is the channel identifier, bit 12 is the sign, and bits 11..0 are the result. Bit 15 appears after the select fall, and each serial clock fall advances one bit. The word is captured at the select fall, so later changes on the result inputs do not affect the frame.
- R4: The command word is received MSB first. Bit 15 is Write, bit 14 must be zero, and bit 13 is Select. With Write=1 and Select=0, command bits 12..1 are loaded into the 12-bit control register on the 15th serial clock fall.
- R5: With Write=1 and Select=1, command bits 12..5 are loaded into the 8-bit range register on the 11th serial clock fall.
- R6: A frame with Write=0 leaves both registers unchanged.
- R7: The must-be-zero bit (command bit 14) is not checked. A frame with that bit set is decoded from Write and Select alone.
- R8: If select rises before 16 falls, the output enable drops. A write whose commit edge was reached is kept, and a write whose commit edge was not reached is dropped.
- R9: The hold strobe pulses exactly once per select fall. The track strobe pulses exactly once, on the 15th serial clock fall of a frame.
- R10: Serial clock edges while select is high shift nothing, commit nothing and leave the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; idles high; falling edges are active |
| din | input | 1 | Serial command data |
| res_chan | input | 1 | Channel identifier of the last conversion |
| res_sign | input | 1 | Sign bit of the last conversion |
| res_data | input | DATA_W | Magnitude bits of the last conversion |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for the serial output (low means high impedance) |
| ctrl_reg | output | CTRL_W | Control register contents |
| range_reg | output | RANGE_W | Range register contents |
| hold_stb | output | 1 | One-cycle pulse at the sampling instant |
| track_stb | output | 1 | One-cycle pulse at the return to tracking |

## Verification
A wrong frame count shows up at the ports within one serial bit time. It appears as a misplaced result bit on the serial output, a track pulse on the wrong fall, or a register that updates on the wrong edge. A corrupt command shift register produces a wrong register value immediately after the commit fall. Aborted frames are used to show that commit timing is tied to the exact edge: a frame stopped one fall before the commit edge must leave the register untouched. Each register is read back after every frame so that a wrong commit cannot go unseen.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int HDR_BITS = 3;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_CTRL  = 2'd1,
      TGT_RANGE = 2'd2
   } tgt_e;

   // header order, first received bit first: write, must-be-zero, select
   function automatic tgt_e hdr_target(input logic wr, input logic sel);
      if (!wr) return TGT_NONE;
      return sel ? TGT_RANGE : TGT_CTRL;
   endfunction
endpackage

// File: rtl/sfe_in_sync.sv
module sfe_in_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfe_frame_ctr.sv
module sfe_frame_ctr #(
   parameter int FRAME_LEN = 16,
   parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             sclk_s,
   output logic             step,
   output logic             cs_fall,
   output logic             cs_rise,
   output logic [CNT_W-1:0] cnt_next,
   output logic [CNT_W-1:0] frame_cnt,
   output logic             hold_stb,
   output logic             track_stb
);
   localparam logic [CNT_W-1:0] LAST_EDGE  = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] TRACK_EDGE = CNT_W'(FRAME_LEN - 1);

   logic cs_q;
   logic sclk_q;
   logic active;

   assign cs_fall  = cs_q & ~cs_n_s;
   assign cs_rise  = ~cs_q & cs_n_s;
   assign step     = active & sclk_q & ~sclk_s & ~cs_n_s;
   assign cnt_next = frame_cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b1;
         sclk_q    <= 1'b1;
         active    <= 1'b0;
         frame_cnt <= LAST_EDGE;
         hold_stb  <= 1'b0;
         track_stb <= 1'b0;
      end else begin
         cs_q      <= cs_n_s;
         sclk_q    <= sclk_s;
         hold_stb  <= cs_fall;
         track_stb <= step && (cnt_next == TRACK_EDGE);
         if (cs_fall) begin
            active    <= 1'b1;
            frame_cnt <= '0;
         end else if (cs_rise) begin
            active <= 1'b0;
         end else if (step) begin
            frame_cnt <= cnt_next;
            if (cnt_next == LAST_EDGE) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sfe_cmd_decode.sv
module sfe_cmd_decode
   import sfe_pkg::*;
#(
   parameter int CTRL_W  = 12,
   parameter int RANGE_W = 8,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_fall,
   input  logic               step,
   input  logic               din_s,
   input  logic [CNT_W-1:0]   cnt_next,
   output logic [CTRL_W-1:0]  ctrl_q,
   output logic [RANGE_W-1:0] range_q
);
   localparam int CTRL_EDGE  = HDR_BITS + CTRL_W;
   localparam int RANGE_EDGE = HDR_BITS + RANGE_W;
   localparam int SR_W       = (CTRL_EDGE > RANGE_EDGE) ? CTRL_EDGE : RANGE_EDGE;

   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] sr_d;
   logic            ctrl_hit;
   logic            range_hit;

   assign sr_d = {sr_q[SR_W-2:0], din_s};

   // header sits in the oldest three bits at each commit edge
   assign ctrl_hit  = step && (cnt_next == CNT_W'(CTRL_EDGE)) &&
                      (hdr_target(sr_d[CTRL_EDGE-1], sr_d[CTRL_EDGE-3]) == TGT_CTRL);
   assign range_hit = step && (cnt_next == CNT_W'(RANGE_EDGE)) &&
                      (hdr_target(sr_d[RANGE_EDGE-1], sr_d[RANGE_EDGE-3]) == TGT_RANGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         ctrl_q  <= '0;
         range_q <= '0;
      end else begin
         if (cs_fall)   sr_q <= '0;
         else if (step) sr_q <= sr_d;
         if (ctrl_hit)  ctrl_q  <= sr_d[CTRL_W-1:0];
         if (range_hit) range_q <= sr_d[RANGE_W-1:0];
      end
   end
endmodule

// File: rtl/sfe_result_tx.sv
module sfe_result_tx #(
   parameter int FRAME_LEN = 16,
   parameter int DATA_W    = 12,
   parameter int CNT_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt_next,
   input  logic              res_chan,
   input  logic              res_sign,
   input  logic [DATA_W-1:0] res_data,
   output logic              dout,
   output logic              dout_oe
);
   logic [FRAME_LEN-1:0] out_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sr  <= '0;
         dout_oe <= 1'b0;
      end else if (cs_fall) begin
         out_sr  <= {2'b00, res_chan, res_sign, res_data};
         dout_oe <= 1'b1;
      end else if (cs_rise) begin
         dout_oe <= 1'b0;
      end else if (step) begin
         out_sr <= {out_sr[FRAME_LEN-2:0], 1'b0};
         if (cnt_next == CNT_W'(FRAME_LEN)) dout_oe <= 1'b0;
      end
   end

   assign dout = out_sr[FRAME_LEN-1];
endmodule

// File: rtl/sfe_serial_port.sv
module sfe_serial_port #(
   parameter int FRAME_LEN   = 16,
   parameter int DATA_W      = 12,
   parameter int CTRL_W      = 12,
   parameter int RANGE_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               din,
   input  logic               res_chan,
   input  logic               res_sign,
   input  logic [DATA_W-1:0]  res_data,
   output logic               dout,
   output logic               dout_oe,
   output logic [CTRL_W-1:0]  ctrl_reg,
   output logic [RANGE_W-1:0] range_reg,
   output logic               hold_stb,
   output logic               track_stb
);
   localparam int CNT_W = $clog2(FRAME_LEN + 1);

   generate
      if (FRAME_LEN != DATA_W + 4) begin : g_bad_frame
         $error("frame must hold two zeros, channel, sign and result");
      end
      if (sfe_pkg::HDR_BITS + CTRL_W > FRAME_LEN) begin : g_bad_ctrl
         $error("control write does not fit in the frame");
      end
      if (sfe_pkg::HDR_BITS + RANGE_W > FRAME_LEN) begin : g_bad_range
         $error("range write does not fit in the frame");
      end
   endgenerate

   logic [2:0]       pins_s;
   logic             cs_n_s, sclk_s, din_s;
   logic             step, cs_fall, cs_rise;
   logic [CNT_W-1:0] cnt_next, frame_cnt;

   sfe_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({cs_n, sclk, din}), .q_o(pins_s)
   );
   assign {cs_n_s, sclk_s, din_s} = pins_s;

   sfe_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s),
      .step(step), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .cnt_next(cnt_next), .frame_cnt(frame_cnt),
      .hold_stb(hold_stb), .track_stb(track_stb)
   );

   sfe_cmd_decode #(.CTRL_W(CTRL_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .step(step), .din_s(din_s),
      .cnt_next(cnt_next), .ctrl_q(ctrl_reg), .range_q(range_reg)
   );

   sfe_result_tx #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .step(step),
      .cnt_next(cnt_next), .res_chan(res_chan), .res_sign(res_sign),
      .res_data(res_data), .dout(dout), .dout_oe(dout_oe)
   );
endmodule

// File: rtl/sfe_serial_port_chk.sv
module sfe_serial_port_chk #(
   parameter int FRAME_LEN = 16,
   parameter int CTRL_W    = 12,
   parameter int RANGE_W   = 8,
   parameter int CNT_W     = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dout_oe,
   input logic [CTRL_W-1:0]  ctrl_reg,
   input logic [RANGE_W-1:0] range_reg,
   input logic               hold_stb,
   input logic               track_stb,
   input logic [CNT_W-1:0]   frame_cnt,
   input logic               cs_rise
);
   localparam int CTRL_EDGE  = 3 + CTRL_W;
   localparam int RANGE_EDGE = 3 + RANGE_W;

   // R2
   oe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_cnt == CNT_W'(FRAME_LEN) |-> !dout_oe);

   // R4
   ctrl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_reg) |-> frame_cnt == CNT_W'(CTRL_EDGE));

   // R5
   range_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(range_reg) |-> frame_cnt == CNT_W'(RANGE_EDGE));

   // R8
   abort_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !dout_oe);

   // R9
   hold_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_stb |=> !hold_stb);

   // R9
   track_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      track_stb |-> frame_cnt == CNT_W'(FRAME_LEN - 1));
endmodule

bind sfe_serial_port sfe_serial_port_chk #(
   .FRAME_LEN(FRAME_LEN), .CTRL_W(CTRL_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dout_oe(dout_oe), .ctrl_reg(ctrl_reg),
   .range_reg(range_reg), .hold_stb(hold_stb), .track_stb(track_stb),
   .frame_cnt(frame_cnt), .cs_rise(cs_rise)
);

// File: tb/test_sfe_serial_port.sv
module test_sfe_serial_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
   logic        res_chan = 1'b0, res_sign = 1'b0;
   logic [11:0] res_data = '0;
   logic        dout, dout_oe, hold_stb, track_stb;
   logic [11:0] ctrl_reg;
   logic [7:0]  range_reg;

   int checks = 0, errors = 0, hold_cnt = 0, track_cnt = 0;
   logic [11:0] m_ctrl = '0;
   logic [7:0]  m_range = '0;
   localparam int HALF = 6;

   always #2 clk = ~clk;

   sfe_serial_port i_sfe_serial_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .res_chan(res_chan), .res_sign(res_sign), .res_data(res_data),
      .dout(dout), .dout_oe(dout_oe), .ctrl_reg(ctrl_reg), .range_reg(range_reg),
      .hold_stb(hold_stb), .track_stb(track_stb)
   );

   always @(posedge clk) begin
      if (hold_stb)  hold_cnt++;
      if (track_stb) track_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] result_word(input logic ch, input logic sg,
                                               input logic [11:0] d);
      return {2'b00, ch, sg, d};
   endfunction

   task automatic frame(input logic [15:0] cmd, input int nclk, input logic ch,
                        input logic sg, input logic [11:0] d);
      logic [15:0] exp_w;
      int h0, t0;
      exp_w = result_word(ch, sg, d);
      res_chan = ch; res_sign = sg; res_data = d;
      h0 = hold_cnt; t0 = track_cnt;
      wclk(2);
      cs_n = 1'b0;
      wclk(3);
      res_chan = ~ch; res_sign = ~sg; res_data = ~d;   // must not leak (R3)
      wclk(HALF);
      chk("R2 oe after select fall", dout_oe, 1);
      chk("R3 first bit", dout, exp_w[15]);
      chk("R9 hold pulse", hold_cnt - h0, 1);
      for (int i = 0; i < nclk; i++) begin
         din = cmd[15-i];
         wclk(HALF);
         sclk = 1'b0;
         wclk(HALF);
         if (i + 1 < 16) begin
            chk("R3 serial bit", dout, exp_w[15-(i+1)]);
            chk("R2 oe in frame", dout_oe, 1);
         end else begin
            chk("R2 oe after last fall", dout_oe, 0);
         end
         sclk = 1'b1;
      end
      wclk(HALF);
      cs_n = 1'b1;
      din = 1'b0;
      wclk(HALF + 2);
      chk("R8 oe after select rise", dout_oe, 0);
      if (nclk >= 15 && cmd[15] && !cmd[13]) m_ctrl = cmd[12:1];
      if (nclk >= 11 && cmd[15] && cmd[13])  m_range = cmd[12:5];
      chk("R4 R6 R7 R8 control", ctrl_reg, m_ctrl);
      chk("R5 R6 R7 R8 range", range_reg, m_range);
      chk("R9 track pulse", track_cnt - t0, (nclk >= 15) ? 1 : 0);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      chk("R1 control reset", ctrl_reg, 0);
      chk("R1 range reset", range_reg, 0);
      chk("R1 oe reset", dout_oe, 0);

      // directed corners
      frame({3'b100, 12'hA5C, 1'b0}, 16, 1'b1, 1'b0, 12'hFFF);   // R4
      frame({3'b101, 8'h3C, 5'h00}, 16, 1'b0, 1'b1, 12'h001);    // R5
      frame({3'b001, 12'h777, 1'b1}, 16, 1'b1, 1'b1, 12'h800);   // R6
      frame({3'b000, 12'h123, 1'b0}, 16, 1'b0, 1'b0, 12'h555);   // R6
      frame({3'b110, 12'h9E1, 1'b1}, 16, 1'b0, 1'b1, 12'hAAA);   // R7
      frame({3'b111, 8'hC3, 5'h1F}, 16, 1'b1, 1'b0, 12'h0F0);    // R7
      frame({3'b100, 12'h0FF, 1'b0}, 14, 1'b1, 1'b1, 12'h123);   // R8 dropped
      frame({3'b100, 12'h0FF, 1'b0}, 15, 1'b0, 1'b0, 12'h321);   // R8 kept
      frame({3'b101, 8'h5A, 5'h00}, 10, 1'b1, 1'b0, 12'h456);    // R8 dropped
      frame({3'b101, 8'h5A, 5'h00}, 11, 1'b0, 1'b1, 12'h654);    // R8 kept

      // R10: serial clocks with select high
      begin
         int t0;
         t0 = track_cnt;
         for (int k = 0; k < 20; k++) begin
            din = 1'b1;
            wclk(HALF); sclk = 1'b0;
            wclk(HALF); sclk = 1'b1;
         end
         wclk(HALF);
         chk("R10 oe idle", dout_oe, 0);
         chk("R10 control idle", ctrl_reg, m_ctrl);
         chk("R10 range idle", range_reg, m_range);
         chk("R10 no track", track_cnt - t0, 0);
         din = 1'b0;
      end

      // constrained random frames
      for (int n = 0; n < 40; n++) begin
         logic [15:0] c;
         int nc;
         c  = 16'($urandom);
         nc = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 15) : 16;
         frame(c, nc, 1'($urandom), 1'($urandom), 12'($urandom));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule